// File: doc/BRIEF.md
# Odd/Even Johnson Counter Clock Divider

This block divides an input clock by any integer from 2 to 10. It uses a five-stage twisted-ring shift register. On every rising clock edge the ring shifts a serial data bit into stage 1. That bit is produced from the inverted stage outputs.

For an even ratio N, the data bit is the inverse of stage N/2. For an odd ratio N, it is the AND of the inverses of stages (N-1)/2 and (N+1)/2. That single gate shortens the ring's cycle by one clock. The output stays a clean square-like wave with two edges per period, and it never carries narrow pulses or spacing that changes from one period to the next.

The divided output is stage 1. This is the data node registered once, so it leaves a flip-flop. The inverted stage outputs are also brought out for observation.

The ratio is captured while reset is asserted. It is used from the first clock after reset is released. A select that changes later has no effect until the next reset. This keeps the ring out of states it could not leave. A captured code outside 2 to 10 holds the ring cleared.

Top module: `jdiv_top`

## Requirements
- R1: While `rst` is high at a rising edge, all stages clear: `div_out` reads 0 and `stage_n` reads all ones. At the first rising edge with `rst` low and a legal captured ratio, `div_out` becomes 1.
- R2: For an even captured ratio N (`ratio_sel` is N in plain binary, N in 2, 4, 6, 8, 10), `div_out` repeats with a period of exactly N clocks. It is high for N/2 of them.
- R3: For an odd captured ratio N (3, 5, 7, 9), `div_out` repeats with a period of exactly N clocks. It is high for (N-1)/2 of them. For example, a 300 kHz input gives 100 kHz at 3 and 33.333 kHz at 9.
- R4: Every output period has exactly one rising and one falling edge. Every high run and every low run after the first rising edge has the same length.
- R5: `stage_n[k]` is the inverse of stage k+1, and `stage_n[0]` is always the inverse of `div_out`. While counting, `stage_n[k]` for k ≥ 1 equals the value of `stage_n[k-1]` one clock earlier.
- R6: A captured select code outside 2 to 10 (for example 0, 1, 11 or 15) holds the ring cleared. `div_out` stays 0 and `stage_n` stays all ones until the next reset.
- R7: A change of `ratio_sel` while `rst` is low does not change the output period or the duty. The new value takes effect only after the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset; captures `ratio_sel` |
| ratio_sel | input | 4 | Division ratio in binary, legal values 2 to 10 |
| div_out | output | 1 | Divided clock, taken from stage 1 |
| stage_n | output | 5 | Inverted outputs of stages 1 to 5 |

## Verification
The first result after reset is due one clock after release: the first rising edge with `rst` low shifts a 1 into stage 1. The bench therefore samples on the falling edge that follows that edge and expects `div_out` high there. Every further output sample is taken on a falling edge, one per clock. Run lengths, edge counts and the one-clock shift between adjacent `stage_n` bits are then compared with what the ratio dictates. Illegal codes and mid-run select changes are judged at the ports over many clocks after the stimulus. For a mid-run change, the original period must persist until the next reset.

// File: rtl/jdiv_pkg.sv
package jdiv_pkg;
  localparam int unsigned JD_STAGES = 5;
  localparam int unsigned JD_SEL_W  = 4;

  function automatic bit jd_ratio_ok(input int unsigned r, input int unsigned stages);
    return (r >= 2) && (r <= 2 * stages);
  endfunction
endpackage

// File: rtl/jdiv_cfg.sv
module jdiv_cfg #(
  parameter int unsigned STAGES = jdiv_pkg::JD_STAGES,
  parameter int unsigned SEL_W  = jdiv_pkg::JD_SEL_W,
  localparam int unsigned IDX_W = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic [SEL_W-1:0] ratio,
  output logic             legal,
  output logic             odd,
  output logic [IDX_W-1:0] tap_idx
);
  logic [SEL_W-1:0] ratio_q;

  // Select is sampled only while reset is held.
  always_ff @(posedge clk) begin
    if (rst) ratio_q <= sel;
  end

  always_comb begin
    ratio   = ratio_q;
    legal   = jdiv_pkg::jd_ratio_ok(int'(ratio_q), STAGES);
    odd     = ratio_q[0];
    tap_idx = legal ? IDX_W'((ratio_q >> 1) - 1) : '0;
  end

  // R7: captured ratio never moves outside reset
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(ratio_q));
endmodule

// File: rtl/jdiv_feedback.sv
module jdiv_feedback #(
  parameter int unsigned STAGES = jdiv_pkg::JD_STAGES,
  localparam int unsigned IDX_W = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic [STAGES-1:0] q,
  input  logic              odd,
  input  logic [IDX_W-1:0]  tap_idx,
  output logic              data_in
);
  logic [STAGES-1:0] pair_term;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_pair
      if (g < STAGES - 1) begin : g_and
        assign pair_term[g] = ~q[g] & ~q[g+1];
      end else begin : g_last
        assign pair_term[g] = ~q[g];
      end
    end
  endgenerate

  always_comb begin
    data_in = 1'b0;
    for (int i = 0; i < STAGES; i++) begin
      if (tap_idx == IDX_W'(i)) data_in = odd ? pair_term[i] : ~q[i];
    end
  end
endmodule

// File: rtl/jdiv_ring.sv
module jdiv_ring #(
  parameter int unsigned STAGES = jdiv_pkg::JD_STAGES
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              data_in,
  output logic [STAGES-1:0] q
);
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (clr) q[g] <= 1'b0;
        else if (g == 0) q[g] <= data_in;
        else q[g] <= q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  // R1: a cleared cycle leaves every stage at zero
  p_clear_r1: assert property (@(posedge clk)
    $past(clr) |-> (q == '0));

  // R5: each stage copies its neighbour while counting
  p_shift_r5: assert property (@(posedge clk) disable iff (clr)
    !$past(clr) |-> (q[STAGES-1:1] == $past(q[STAGES-2:0])));
endmodule

// File: rtl/jdiv_top.sv
module jdiv_top #(
  parameter int unsigned STAGES = jdiv_pkg::JD_STAGES,
  parameter int unsigned SEL_W  = jdiv_pkg::JD_SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  ratio_sel,
  output logic              div_out,
  output logic [STAGES-1:0] stage_n
);
  localparam int unsigned IDX_W = (STAGES > 1) ? $clog2(STAGES) : 1;
  localparam int unsigned RUN_W = $clog2(2 * STAGES + 2);

  logic [SEL_W-1:0]  ratio;
  logic              legal, odd, data_in, run_clr;
  logic [IDX_W-1:0]  tap_idx;
  logic [STAGES-1:0] q;

  jdiv_cfg #(.STAGES(STAGES), .SEL_W(SEL_W)) u_cfg (
    .clk(clk), .rst(rst), .sel(ratio_sel),
    .ratio(ratio), .legal(legal), .odd(odd), .tap_idx(tap_idx)
  );

  jdiv_feedback #(.STAGES(STAGES)) u_fb (
    .q(q), .odd(odd), .tap_idx(tap_idx), .data_in(data_in)
  );

  // Illegal captured ratio keeps the ring parked in its cleared state.
  assign run_clr = rst | ~legal;

  jdiv_ring #(.STAGES(STAGES)) u_ring (
    .clk(clk), .clr(run_clr), .data_in(data_in), .q(q)
  );

  assign div_out = q[0];
  assign stage_n = ~q;

  // Run-length watcher supporting the period assertions.
  logic             prev_q, armed;
  logic [RUN_W-1:0] run_cnt, hi_len, lo_len;

  assign hi_len = RUN_W'(ratio >> 1);
  assign lo_len = RUN_W'(ratio) - hi_len;

  always_ff @(posedge clk) begin
    if (run_clr) begin
      prev_q  <= 1'b0;
      armed   <= 1'b0;
      run_cnt <= '0;
    end else begin
      prev_q <= div_out;
      if (div_out != prev_q) begin
        run_cnt <= RUN_W'(1);
        if (div_out) armed <= 1'b1;
      end else begin
        run_cnt <= run_cnt + RUN_W'(1);
      end
    end
  end

  // R4 (with R2/R3): high runs have the fixed length
  p_high_len_r4: assert property (@(posedge clk) disable iff (run_clr)
    (armed && prev_q && !div_out) |-> (run_cnt == hi_len));

  // R4: low runs have the fixed length
  p_low_len_r4: assert property (@(posedge clk) disable iff (run_clr)
    (armed && !prev_q && div_out) |-> (run_cnt == lo_len));

  // R6: an illegal ratio keeps the output low
  p_illegal_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !legal |-> (!div_out && (stage_n == '1)));
endmodule

// File: tb/jdiv_top_bench.sv
module jdiv_top_bench;
  localparam int NS = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    ratio_sel = 4'd2;
  logic          div_out;
  logic [NS-1:0] stage_n;

  int n_checks = 0;
  int n_fail   = 0;

  jdiv_top u_jdiv_top (
    .clk(clk), .rst(rst), .ratio_sel(ratio_sel),
    .div_out(div_out), .stage_n(stage_n)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input int sel);
    @(negedge clk);
    ratio_sel = 4'(sel);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    // R1: cleared state seen while reset is held
    chk(div_out == 1'b0 && stage_n == '1, "R1", "reset state",
        int'({div_out, stage_n}), int'({1'b0, {NS{1'b1}}}));
    rst = 1'b0;
    @(negedge clk);
  endtask

  // Measures 'cycles' samples starting at the current falling edge.
  task automatic measure(input int n, input int cycles, input string req,
                         output int bad_runs, output int rises, output int highs,
                         output int bad_stage);
    bit prev = 1'b1;
    bit [NS-1:0] prev_sn = '0;
    int run = 0;
    bad_runs = 0; rises = 1; highs = 0; bad_stage = 0;
    for (int c = 0; c < cycles; c++) begin
      if (c > 0) @(negedge clk);
      if (stage_n[0] != ~div_out) bad_stage++;
      if (c > 0) begin
        for (int k = 1; k < NS; k++)
          if (stage_n[k] != prev_sn[k-1]) bad_stage++;
      end
      if (div_out) highs++;
      if (c > 0 && div_out != prev) begin
        if (prev && run != (n >> 1)) bad_runs++;
        if (!prev && run != n - (n >> 1)) bad_runs++;
        if (div_out) rises++;
        run = 1;
      end else begin
        run++;
      end
      prev = div_out;
      prev_sn = stage_n;
    end
  endtask

  task automatic run_ratio(input int n);
    int bad_runs, rises, highs, bad_stage;
    string req;
    req = (n % 2 == 0) ? "R2" : "R3";
    do_reset(n);
    chk(div_out == 1'b1, "R1", "first output after release", int'(div_out), 1);
    measure(n, 20 * n, req, bad_runs, rises, highs, bad_stage);
    chk(bad_runs == 0, req, "run lengths wrong", bad_runs, 0);
    chk(highs == 20 * (n >> 1), req, "high clocks in 20 periods", highs, 20 * (n >> 1));
    chk(rises == 20, "R4", "rising edges in 20 periods", rises, 20);
    chk(bad_stage == 0, "R5", "stage output mismatches", bad_stage, 0);
  endtask

  task automatic run_illegal(input int sel);
    int ones = 0;
    do_reset(sel);
    for (int c = 0; c < 40; c++) begin
      if (div_out != 1'b0 || stage_n != '1) ones++;
      @(negedge clk);
    end
    chk(ones == 0, "R6", $sformatf("illegal select %0d not held", sel), ones, 0);
  endtask

  task automatic run_change();
    int bad_runs, rises, highs, bad_stage;
    do_reset(3);
    repeat (6) @(negedge clk);
    ratio_sel = 4'd9;
    @(negedge clk);
    // first sample: align to a rising edge of the output
    while (!(div_out == 1'b1 && stage_n[1] == 1'b1)) @(negedge clk);
    measure(3, 60, "R7", bad_runs, rises, highs, bad_stage);
    chk(bad_runs == 0, "R7", "runs after mid-run select change", bad_runs, 0);
    chk(rises == 20, "R7", "rising edges after select change", rises, 20);
    // new ratio applies only after a reset
    run_ratio(9);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(1'b0, "R4", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    for (int n = 2; n <= 10; n++) run_ratio(n);
    run_illegal(0);
    run_illegal(1);
    run_illegal(11);
    run_illegal(15);
    run_change();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule